// File: doc/BRIEF.md
# Selective Verify-and-Retry Write Sequencer

This block sequences word writes into a resistive non-volatile array whose cells switch towards 0 and towards 1 only under opposite current directions. A host asks for one word to be written. The sequencer first reads the stored word and compares it with the new value. It then pulses only the bits that actually change. Those bits are split into groups of at most `GMAX` bits, taken lowest bit first. Within each group the bits that must go low are handled first, then the bits that must go high, each polarity with its own bias setup and its own pulse strobe.

Every pulse is followed by a verify read. Bits that now read back correctly are removed from the next pulse. A polarity phase stops when all of its bits have verified, or when `PMAX` pulses have been spent. Bits that still fail do not stop the sequence: the remaining groups are written, and the final status then reports a failure. The host sees a ready signal that stays low for the whole operation and a one-cycle status strobe carrying the fail flag.

Top module: `selwr_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `host_rdy` is 1 and `st_vld`, `arr_rd`, `arr_p0`, `arr_p1` and `arr_bias` are all 0.
- R2: After a request is accepted, the first array operation is a read (`arr_rd`) at the requested address; `arr_addr` carries the latched address for the whole operation.
- R3: If the stored word already equals the new data, no bias or pulse strobe is issued and the status reports success.
- R4: Only bits whose stored value differs from the new data are pulsed; `arr_p0` (drive cell to 0) carries only bits whose new value is 0, `arr_p1` (drive cell to 1) only bits whose new value is 1; after a successful write the stored word equals the new data.
- R5: Changed bits are grouped in ascending bit order; each group holds the lowest up to `GMAX` changed bits not yet grouped, so no pulse mask has more than `GMAX` ones.
- R6: Within a group the 0-phase runs before the 1-phase, and a phase with no bits is skipped entirely (no bias, no pulse).
- R7: Each phase that runs begins with exactly `BIAS_CYC` consecutive cycles of `arr_bias`, directly followed by its first pulse.
- R8: Every pulse is followed in the next cycle by a verify read, and each retry pulse carries exactly the bits of that phase that have not yet read back correctly.
- R9: A phase issues at most `PMAX` pulses; if bits still fail after that, the remaining groups are still written and `st_fail` is 1 with the status.
- R10: At most one of `arr_rd`, `arr_p0`, `arr_p1`, `arr_bias` is high in any cycle; `host_rdy` is 0 from request acceptance until the cycle after the one-cycle `st_vld` strobe, when it returns to 1.
- R11: The fail flag belongs to one request only: a write that follows a failed write reports success if its own bits all verify.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Write request, taken when `host_rdy` is 1 |
| host_addr | input | AW | Word address of the request |
| host_wdata | input | DW | New word value |
| host_rdy | output | 1 | Sequencer idle and able to accept a request |
| st_vld | output | 1 | One-cycle final status strobe |
| st_fail | output | 1 | With `st_vld`: some bit never verified |
| arr_addr | output | AW | Array word address |
| arr_rd | output | 1 | Array read strobe; data returns next cycle |
| arr_p0 | output | 1 | Pulse strobe switching masked cells to 0 |
| arr_p1 | output | 1 | Pulse strobe switching masked cells to 1 |
| arr_bias | output | 1 | Bias setup strobe before a pulse phase |
| arr_mask | output | DW | Bit-select mask, valid with a pulse strobe |
| arr_rdata | input | DW | Array read data, one cycle after `arr_rd` |

## Verification
The bench pairs a cell-array model, whose bits each need a configurable number of pulses to switch, with a predictor that derives from the requirements the exact list of pulse polarities and masks, the bias cycle count, the final word and the fail flag. An unchanged word separates a true pre-read skip from blind writing; single-polarity words whose changes fall in one half show whether empty phases are skipped; mixed words wider than one group expose the ascending grouping and the 0-before-1 order. Bits needing several pulses tell correct mask shrinking apart from re-pulsing verified bits, a bit needing more than `PMAX` pulses shows the sequence finishing later groups before reporting failure, and a following clean write shows that the flag does not persist; random words with random pulse needs mix all of these.

// File: rtl/selwr_pkg.sv
package selwr_pkg;

    typedef enum logic [3:0] {
        S_IDLE  = 4'd0,
        S_PRE   = 4'd1,
        S_PCAP  = 4'd2,
        S_GRP   = 4'd3,
        S_BIAS  = 4'd4,
        S_PULSE = 4'd5,
        S_VRD   = 4'd6,
        S_VCAP  = 4'd7,
        S_DONE  = 4'd8
    } selwr_st_e;

endpackage

// File: rtl/selwr_grp_pick.sv
module selwr_grp_pick #(
    parameter int DW   = 16,
    parameter int GMAX = 4
) (
    input  logic [DW-1:0] pend,
    output logic [DW-1:0] sel
);
    localparam int CW = $clog2(DW + 1);

    // running count of pending bits below each position
    logic [CW-1:0] below [DW+1];

    assign below[0] = '0;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign below[i+1] = below[i] + CW'(pend[i]);
        assign sel[i]     = pend[i] & (below[i] < CW'(GMAX));
    end

endmodule

// File: rtl/selwr_bias_tmr.sv
module selwr_bias_tmr #(
    parameter int CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int TW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = run && (cnt_q == TW'(CYC - 1));
        cnt_d = cnt_q;
        if (!run || last) cnt_d = '0;
        else              cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/selwr_ctrl.sv
module selwr_ctrl
    import selwr_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 4,
    parameter int GMAX     = 4,
    parameter int PMAX     = 3,
    parameter int BIAS_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_rdy,
    output logic          st_vld,
    output logic          st_fail,
    output logic [AW-1:0] arr_addr,
    output logic          arr_rd,
    output logic          arr_p0,
    output logic          arr_p1,
    output logic          arr_bias,
    output logic [DW-1:0] arr_mask,
    input  logic [DW-1:0] arr_rdata
);
    localparam int PCW = $clog2(PMAX + 1);

    typedef struct packed {
        selwr_st_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] pend;    // changed bits not yet grouped
        logic [DW-1:0] grp;     // current group
        logic [DW-1:0] live;    // bits of current phase still unverified
        logic [PCW-1:0] pcnt;
        logic          phase;   // 0: drive to 0, 1: drive to 1
        logic          fail;
    } ctl_t;

    ctl_t d, q;

    logic [DW-1:0] pick;
    logic          bias_last;
    logic [DW-1:0] diff_rd;
    logic [DW-1:0] bad;
    logic [DW-1:0] lo_bits;
    logic [DW-1:0] hi_bits;

    selwr_grp_pick #(.DW(DW), .GMAX(GMAX)) u_pick (
        .pend (q.pend),
        .sel  (pick)
    );

    selwr_bias_tmr #(.CYC(BIAS_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st == S_BIAS),
        .last  (bias_last)
    );

    always_comb begin
        d        = q;
        host_rdy = 1'b0;
        st_vld   = 1'b0;
        st_fail  = 1'b0;
        arr_rd   = 1'b0;
        arr_p0   = 1'b0;
        arr_p1   = 1'b0;
        arr_bias = 1'b0;
        arr_mask = '0;
        arr_addr = q.addr;
        diff_rd  = arr_rdata ^ q.wdata;
        bad      = q.live & diff_rd;
        lo_bits  = pick & ~q.wdata;
        hi_bits  = q.grp & q.wdata;

        unique case (q.st)
            S_IDLE: begin
                host_rdy = 1'b1;
                if (host_req) begin
                    d.addr  = host_addr;
                    d.wdata = host_wdata;
                    d.fail  = 1'b0;
                    d.st    = S_PRE;
                end
            end
            S_PRE: begin
                arr_rd = 1'b1;
                d.st   = S_PCAP;
            end
            S_PCAP: begin
                d.pend = diff_rd;
                d.st   = (diff_rd == '0) ? S_DONE : S_GRP;
            end
            S_GRP: begin
                d.grp  = pick;
                d.pend = q.pend & ~pick;
                d.pcnt = '0;
                d.st   = S_BIAS;
                if (lo_bits != '0) begin
                    d.phase = 1'b0;
                    d.live  = lo_bits;
                end else begin
                    d.phase = 1'b1;
                    d.live  = pick & q.wdata;
                end
            end
            S_BIAS: begin
                arr_bias = 1'b1;
                if (bias_last) d.st = S_PULSE;
            end
            S_PULSE: begin
                arr_p0   = ~q.phase;
                arr_p1   = q.phase;
                arr_mask = q.live;
                d.pcnt   = q.pcnt + PCW'(1);
                d.st     = S_VRD;
            end
            S_VRD: begin
                arr_rd = 1'b1;
                d.st   = S_VCAP;
            end
            S_VCAP: begin
                d.live = bad;
                if (bad != '0 && q.pcnt < PCW'(PMAX)) begin
                    d.st = S_PULSE;
                end else begin
                    if (bad != '0) d.fail = 1'b1;
                    if (!q.phase && hi_bits != '0) begin
                        d.phase = 1'b1;
                        d.live  = hi_bits;
                        d.pcnt  = '0;
                        d.st    = S_BIAS;
                    end else begin
                        d.st = (q.pend != '0) ? S_GRP : S_DONE;
                    end
                end
            end
            S_DONE: begin
                st_vld  = 1'b1;
                st_fail = q.fail;
                d.st    = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // ------------------------------------------------------------------
    // Assertions
    // ------------------------------------------------------------------
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd, arr_p0, arr_p1, arr_bias}));

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd || arr_p0 || arr_p1 || arr_bias) |-> !host_rdy);

    assert_status_then_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_vld |=> (host_rdy && !st_vld));

    assert_group_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_p0 || arr_p1) |-> ($countones(arr_mask) <= GMAX && arr_mask != '0));

    assert_pick_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_GRP) |-> (pick != '0 && (pick & ~q.pend) == '0));

    assert_p0_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_p0 |-> ((arr_mask & q.wdata) == '0));

    assert_p1_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_p1 |-> ((arr_mask & ~q.wdata) == '0));

    assert_bias_into_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_bias |=> (arr_bias || arr_p0 || arr_p1));

    assert_pulse_then_verify_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_p0 || arr_p1) |=> arr_rd);

    assert_pulse_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt <= PCW'(PMAX));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdy && !st_vld) |=> $stable(arr_addr));

endmodule

// File: tb/selwr_ctrl_test.sv
`timescale 1ns/1ps
module selwr_ctrl_test;
    localparam int DW = 16, AW = 4, GMAX = 4, PMAX = 3, BIAS = 2;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rdy, st_vld, st_fail;
    logic [AW-1:0] arr_addr;
    logic          arr_rd, arr_p0, arr_p1, arr_bias;
    logic [DW-1:0] arr_mask;
    logic [DW-1:0] arr_rdata = '0;

    selwr_ctrl #(.DW(DW), .AW(AW), .GMAX(GMAX), .PMAX(PMAX), .BIAS_CYC(BIAS)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdy(host_rdy), .st_vld(st_vld), .st_fail(st_fail),
        .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_p0(arr_p0), .arr_p1(arr_p1),
        .arr_bias(arr_bias), .arr_mask(arr_mask), .arr_rdata(arr_rdata)
    );

    always #4 clk = ~clk;   // 125 MHz

    int nchk = 0, nerr = 0;

    // ---------------- cell array model ----------------
    logic [DW-1:0] mem [1<<AW];
    int            need_cfg [DW];
    int            hits [DW];
    logic          pl_en = 1'b0, clr_hits = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [DW-1:0] pl_data = '0;

    always @(posedge clk) begin
        if (pl_en) mem[pl_addr] <= pl_data;
        if (clr_hits) for (int i = 0; i < DW; i++) hits[i] = 0;
        if (arr_rd) arr_rdata <= mem[arr_addr];
        if (arr_p0 || arr_p1) begin
            for (int i = 0; i < DW; i++) begin
                if (arr_mask[i]) begin
                    hits[i] = hits[i] + 1;
                    if (hits[i] >= need_cfg[i]) mem[arr_addr][i] <= arr_p1;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [DW:0]   exp_pulse [$];
    logic          exp_fail [$];
    logic [DW-1:0] exp_word [$];
    logic [AW-1:0] exp_addr [$];
    int            exp_bias [$];
    int            bias_seen = 0;
    logic          fresh = 1'b0;
    logic          rdy_next = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // predictor built from R4-R9
    task automatic predict(input logic [DW-1:0] old, input logic [DW-1:0] nw);
        int rem [DW];
        logic [DW-1:0] pend, grp, live, fin;
        int taken, n, nb;
        logic fl;
        for (int i = 0; i < DW; i++) rem[i] = (need_cfg[i] < 1) ? 1 : need_cfg[i];
        pend = old ^ nw; fin = old; fl = 1'b0; nb = 0;
        while (pend != '0) begin
            grp = '0; taken = 0;
            for (int i = 0; i < DW; i++)
                if (pend[i] && taken < GMAX) begin grp[i] = 1'b1; taken++; end
            pend = pend & ~grp;
            for (int pol = 0; pol < 2; pol++) begin
                live = grp & ((pol == 1) ? nw : ~nw);
                if (live != '0) nb += BIAS;
                n = 0;
                while (live != '0 && n < PMAX) begin
                    exp_pulse.push_back({pol[0], live});
                    n++;
                    for (int i = 0; i < DW; i++) begin
                        if (live[i]) begin
                            rem[i]--;
                            if (rem[i] == 0) begin live[i] = 1'b0; fin[i] = nw[i]; end
                        end
                    end
                end
                if (live != '0) fl = 1'b1;
            end
        end
        exp_fail.push_back(fl);
        exp_word.push_back(fin);
        exp_bias.push_back(nb);
    endtask

    task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = a; pl_data = v;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        while (!host_rdy) @(negedge clk);
        predict(mem[a], v);
        exp_addr.push_back(a);
        clr_hits = 1'b1;
        host_req = 1'b1; host_addr = a; host_wdata = v; fresh = 1'b1;
        @(negedge clk);
        clr_hits = 1'b0;
        host_req = 1'b0;
        while (exp_fail.size() != 0) @(negedge clk);
    endtask

    task automatic set_need(input int all);
        for (int i = 0; i < DW; i++) need_cfg[i] = all;
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rdy_next) begin
                check(host_rdy === 1'b1, "R10 ready after status", 32'(host_rdy), 1);
                rdy_next = 1'b0;
            end
            if ((arr_rd || arr_p0 || arr_p1 || arr_bias) && host_rdy)
                check(1'b0, "R10 ready during operation", 1, 0);
            if (fresh && (arr_rd || arr_p0 || arr_p1 || arr_bias)) begin
                check(arr_rd === 1'b1 && arr_addr === host_addr, "R2 pre-read first",
                      {arr_rd, 27'd0, arr_addr}, {1'b1, 27'd0, host_addr});
                fresh = 1'b0;
            end
            if (arr_bias) bias_seen++;
            if (arr_p0 || arr_p1) begin
                if (exp_pulse.size() == 0)
                    check(1'b0, "R8 unexpected pulse", 32'({arr_p1, arr_mask}), 0);
                else begin
                    logic [DW:0] e;
                    e = exp_pulse.pop_front();
                    check({arr_p1, arr_mask} === e, "R4/R5/R6/R8 pulse polarity and mask",
                          32'({arr_p1, arr_mask}), 32'(e));
                end
            end
            if (st_vld) begin
                if (exp_fail.size() == 0)
                    check(1'b0, "R10 unexpected status", 1, 0);
                else begin
                    logic ef; logic [DW-1:0] ew; logic [AW-1:0] ea; int eb;
                    ef = exp_fail.pop_front(); ew = exp_word.pop_front();
                    ea = exp_addr.pop_front(); eb = exp_bias.pop_front();
                    check(st_fail === ef, "R9/R11 status fail flag", 32'(st_fail), 32'(ef));
                    check(mem[ea] === ew, "R4 stored word", 32'(mem[ea]), 32'(ew));
                    check(bias_seen == eb, "R7 bias cycles", bias_seen, eb);
                    check(exp_pulse.size() == 0, "R3/R9 missing pulses", exp_pulse.size(), 0);
                    exp_pulse.delete();
                    bias_seen = 0;
                    rdy_next  = 1'b1;
                end
            end
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        for (int i = 0; i < DW; i++) hits[i] = 0;
        set_need(1);
        repeat (3) @(negedge clk);
        // R1 during reset
        check(host_rdy === 1'b1 && st_vld === 1'b0, "R1 reset outputs", {host_rdy, st_vld}, 2'b10);
        check({arr_rd, arr_p0, arr_p1, arr_bias} === 4'b0, "R1 reset strobes",
              {arr_rd, arr_p0, arr_p1, arr_bias}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_rdy === 1'b1 && {arr_rd, arr_p0, arr_p1, arr_bias} === 4'b0,
              "R1 after reset", {host_rdy, arr_rd, arr_p0, arr_p1, arr_bias}, 5'b10000);

        // R3: unchanged word, no pulses or bias
        preload(4'd3, 16'hA5C3);
        do_write(4'd3, 16'hA5C3);

        // R4: single bit to 1
        preload(4'd1, 16'h0000);
        do_write(4'd1, 16'h0001);

        // R6: first group only 1-writes, second only 0-writes
        preload(4'd2, 16'hF0F0);
        do_write(4'd2, 16'h0FF0);

        // R5: mixed word wider than one group
        preload(4'd4, 16'h00FF);
        do_write(4'd4, 16'h5A5A);

        // R5: all bits flip, four groups
        preload(4'd6, 16'hFFFF);
        do_write(4'd6, 16'h0000);

        // R8: stubborn bits verified after retries
        need_cfg[1] = 3; need_cfg[6] = 2; need_cfg[12] = 2;
        preload(4'd5, 16'h0000);
        do_write(4'd5, 16'hFFFF);

        // R9: bit 9 never switches, later groups still written
        set_need(1);
        need_cfg[9] = PMAX + 1;
        preload(4'd7, 16'h1234);
        do_write(4'd7, 16'hEDCB);

        // R11: next write after failure succeeds
        set_need(1);
        do_write(4'd7, 16'h8001);

        // mixed random words and pulse needs
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < DW; i++) need_cfg[i] = 1 + ($urandom % 4 == 0 ? ($urandom % (PMAX + 1)) : 0);
            do_write(AW'($urandom), DW'($urandom));
        end

        repeat (4) @(negedge clk);
        check(host_rdy === 1'b1 && exp_fail.size() == 0, "R10 idle at end", 32'(host_rdy), 1);
        finish_run();
    end

endmodule